// File: doc/BRIEF.md
# Stored-Tune Playback Sequencer

This block plays a short tune held in a small on-chip word store. The tune is stored as packed note words. While the play enable input is high, the sequencer waits a fixed start-up interval. It then walks the store from address 0, one word per note, and drives a square-wave tone on a single output pin. When the enable drops, the output falls silent in the same cycle and the sequencer goes back to idle.

Each word carries two codes: a three-bit duration code that selects a number of beat ticks, and a five-bit pitch code that selects the tone half period. The pitch code can also mark a silent note. A five-bit tempo input sets how many clock cycles make one beat tick. One reserved word value marks the end of the tune: on reaching it, the sequencer returns to address 0 and plays the tune again, and any words stored beyond it are never played. When two consecutive notes share a pitch, the tone keeps its phase across the boundary, so the two notes sound as one tied note.

The start-up interval is a fixed number of reference cycles plus the number of cycles in 1/128 s, so it follows the reference frequency given as a parameter. The store is loaded through a plain synchronous write port.

Top module: `tune_player`

## Requirements
- R1: Whenever `play_en` is low, `tone_out` is low in the same cycle, and after the next clock edge the sequencer is idle.
- R2: After `play_en` rises, counting the first rising clock edge that samples it high as edge 1, `tone_out` first goes high on edge START_CYC + REF_HZ/128 + 2, provided word 0 is a sounding note.
- R3: A word holds its duration code in bits [7:5], and codes 0 to 7 select 1, 2, 3, 4, 6, 8, 12 and 16 beat ticks. A word of N ticks occupies N×P + 1 clock cycles, where P is the tick length from R4.
- R4: The tick length is P = TEMPO_BASE + TEMPO_STEP × `tempo_code` clock cycles, and it is taken from `tempo_code` when each note is loaded.
- R5: The word 8'h5F marks the end of the tune. It takes one clock cycle, sends the address back to 0, and no word stored after it is ever played. If 8'h5F sits at address 0, the output stays low for as long as `play_en` is high.
- R6: A word holds its pitch code in bits [4:0]. Codes 0 to 26 produce a square wave whose high and low phases each last PITCH_BASE − PITCH_STEP × code cycles. A sounding note that follows a silent note or a different pitch starts in its high phase.
- R7: Pitch code 31 is a rest, and codes 27 to 30 are also silent. During such a word `tone_out` is low for the whole word.
- R8: When a note has the same sounding pitch as the note before it, the tone continues without restarting its phase, and this holds across the end-word wrap as well.
- R9: Every rising edge of `play_en` restarts the tune from address 0 after the full start-up interval.
- R10: While `rst` is high and after it is released with `play_en` low, `tone_out` is low.
- R11: When `wr_en` is high on a rising clock edge, `wr_data` is stored at `wr_addr`. Playback reads back the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| play_en | input | 1 | High: play the tune repeatedly; low: silence and idle |
| tempo_code | input | 5 | Selects the beat tick length |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | $clog2(DEPTH) | Store write address |
| wr_data | input | 8 | Word to store (duration code, pitch code) |
| tone_out | output | 1 | Square-wave tone output |

## Verification
The bench counts clock cycles to the first tone edge after enable. A start-up counter that is off by one, or that is not re-armed on a new rising edge of enable, shifts this count. It measures the high and low runs of the tone for short notes, rests and a tune that wraps. A wrong tick table, a wrong tempo formula, a missing fetch cycle, or an end word that is not honoured changes these run lengths. It also plays two tied notes of the same pitch: a design that restarts the phase at every note keeps the output high indefinitely instead of toggling after one half period. Silent pitch codes, an end word at address 0, and a drop of enable in the middle of a high phase each have to give a low output with no delay.

// File: rtl/tune_pkg.sv
package tune_pkg;

    localparam logic [7:0] END_WORD  = 8'h5F;
    localparam logic [4:0] TOP_PITCH = 5'd26;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_FETCH,
        ST_PLAY
    } seq_state_t;

    typedef struct packed {
        logic [2:0] len;
        logic [4:0] pitch;
    } note_t;

    // duration code -> number of beat ticks (plain and dotted values)
    function automatic logic [4:0] len_ticks(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd3;
            3'd3:    return 5'd4;
            3'd4:    return 5'd6;
            3'd5:    return 5'd8;
            3'd6:    return 5'd12;
            default: return 5'd16;
        endcase
    endfunction

    // rest code and the unused codes above the pitch range are silent
    function automatic logic pitch_silent(input logic [4:0] p);
        return p > TOP_PITCH;
    endfunction

endpackage

// File: rtl/tune_store.sv
module tune_store #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tune_beat.sv
module tune_beat #(
    parameter int unsigned PW = 11,
    parameter int unsigned TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [PW-1:0] reload,
    input  logic [TW-1:0] ticks,
    output logic          done
);

    logic [PW-1:0] presc;
    logic [PW-1:0] reload_q;
    logic [TW-1:0] left;

    assign done = run && (presc == '0) && (left == TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            presc    <= '0;
            reload_q <= '0;
            left     <= '0;
        end else if (load) begin
            reload_q <= reload;
            presc    <= reload - 1'b1;
            left     <= ticks;
        end else if (run) begin
            if (presc == '0) begin
                presc <= reload_q - 1'b1;
                left  <= left - 1'b1;
            end else begin
                presc <= presc - 1'b1;
            end
        end
    end

    // R4: the prescaler stays inside the tick length taken at note load
    assert_presc_range_R4: assert property (@(posedge clk) disable iff (rst)
        run |-> (presc < reload_q));

    // R3: a running note always has at least one tick left
    assert_ticks_left_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (left != '0));

endmodule

// File: rtl/tune_tone.sv
module tune_tone
    import tune_pkg::*;
#(
    parameter int unsigned HW         = 6,
    parameter int unsigned PITCH_BASE = 48,
    parameter int unsigned PITCH_STEP = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       load,
    input  logic [4:0] pitch,
    output logic       tone
);

    logic          tone_q;
    logic          silent_q;
    logic [4:0]    cur_pitch;
    logic [HW-1:0] cnt;
    logic [HW-1:0] half_q;
    logic [HW-1:0] half_w;
    logic          restart;

    assign half_w  = HW'(PITCH_BASE - PITCH_STEP * int'(pitch));
    assign restart = silent_q || (pitch != cur_pitch);
    assign tone    = tone_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tone_q    <= 1'b0;
            silent_q  <= 1'b1;
            cur_pitch <= '0;
            cnt       <= '0;
            half_q    <= '0;
        end else if (load && pitch_silent(pitch)) begin
            tone_q    <= 1'b0;
            silent_q  <= 1'b1;
            cur_pitch <= pitch;
        end else if (load && restart) begin
            tone_q    <= 1'b1;
            silent_q  <= 1'b0;
            cur_pitch <= pitch;
            half_q    <= half_w;
            cnt       <= half_w - 1'b1;
        end else if (!silent_q) begin
            // also reached on a tied load: the phase carries on
            if (cnt == '0) begin
                cnt    <= half_q - 1'b1;
                tone_q <= ~tone_q;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R7: a silent note never drives the tone high
    assert_rest_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        silent_q |-> !tone_q);

    // R6: a freshly started pitch opens in its high phase
    assert_tone_start_R6: assert property (@(posedge clk) disable iff (rst)
        (load && !clear && !pitch_silent(pitch) && restart) |=> tone_q);

endmodule

// File: rtl/tune_player.sv
module tune_player
    import tune_pkg::*;
#(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned START_CYC  = 256,
    parameter int unsigned REF_HZ     = 32768,
    parameter int unsigned TEMPO_BASE = 256,
    parameter int unsigned TEMPO_STEP = 32,
    parameter int unsigned PITCH_BASE = 48,
    parameter int unsigned PITCH_STEP = 1,
    localparam int unsigned AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          play_en,
    input  logic [4:0]    tempo_code,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          tone_out
);

    localparam int unsigned DELAY_TOTAL = START_CYC + REF_HZ / 128;
    localparam int unsigned DW          = $clog2(DELAY_TOTAL + 1);
    localparam int unsigned PW          = $clog2(TEMPO_BASE + 31 * TEMPO_STEP + 1);
    localparam int unsigned TW          = 5;
    localparam int unsigned HW          = $clog2(PITCH_BASE + 1);

    seq_state_t    state;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] dly;
    logic [7:0]    rd_word;
    note_t         note;
    logic          is_end;
    logic          note_load;
    logic          beat_done;
    logic          tone_q;
    logic [PW-1:0] reload_w;

    assign note      = note_t'(rd_word);
    assign is_end    = (rd_word == END_WORD);
    assign note_load = play_en && (state == ST_FETCH) && !is_end;
    assign reload_w  = PW'(TEMPO_BASE + TEMPO_STEP * int'(tempo_code));
    assign tone_out  = tone_q && play_en;

    always_ff @(posedge clk) begin
        if (rst || !play_en) begin
            state   <= ST_IDLE;
            rd_addr <= '0;
            dly     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state   <= ST_START;
                    rd_addr <= '0;
                    dly     <= DW'(DELAY_TOTAL - 1);
                end
                ST_START: begin
                    if (dly == '0) state <= ST_FETCH;
                    else           dly   <= dly - 1'b1;
                end
                ST_FETCH: begin
                    if (is_end) begin
                        rd_addr <= '0;
                    end else begin
                        rd_addr <= rd_addr + 1'b1;
                        state   <= ST_PLAY;
                    end
                end
                default: begin
                    if (beat_done) state <= ST_FETCH;
                end
            endcase
        end
    end

    tune_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    tune_beat #(.PW(PW), .TW(TW)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .load   (note_load),
        .run    (state == ST_PLAY),
        .reload (reload_w),
        .ticks  (len_ticks(note.len)),
        .done   (beat_done)
    );

    tune_tone #(
        .HW         (HW),
        .PITCH_BASE (PITCH_BASE),
        .PITCH_STEP (PITCH_STEP)
    ) u_tone (
        .clk   (clk),
        .rst   (rst),
        .clear (!play_en),
        .load  (note_load),
        .pitch (note.pitch),
        .tone  (tone_q)
    );

    // R1: with the enable low the sequencer drops to idle
    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !play_en |=> (state == ST_IDLE));

    // R9: a new start re-arms the delay from address 0
    assert_rearm_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && play_en) |=> (state == ST_START && rd_addr == '0));

    // R5: the end word sends the address back to 0 and fetches again
    assert_end_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && play_en && is_end) |=> (rd_addr == '0 && state == ST_FETCH));

endmodule

// File: tb/tune_player_tb.sv
module tune_player_tb;

    localparam int START_CYC  = 4;
    localparam int REF_HZ     = 1280;
    localparam int TEMPO_BASE = 2;
    localparam int TEMPO_STEP = 1;
    localparam int PITCH_BASE = 40;
    localparam int PITCH_STEP = 1;
    localparam int DELAY      = START_CYC + REF_HZ / 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       play_en = 1'b0;
    logic [4:0] tempo_code = '0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tone_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tune_player #(
        .DEPTH      (64),
        .START_CYC  (START_CYC),
        .REF_HZ     (REF_HZ),
        .TEMPO_BASE (TEMPO_BASE),
        .TEMPO_STEP (TEMPO_STEP),
        .PITCH_BASE (PITCH_BASE),
        .PITCH_STEP (PITCH_STEP)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .play_en    (play_en),
        .tempo_code (tempo_code),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tone_out   (tone_out)
    );

    function automatic int ticks_of(input int code);
        case (code)
            0: return 1;  1: return 2;  2: return 3;  3: return 4;
            4: return 6;  5: return 8;  6: return 12; default: return 16;
        endcase
    endfunction

    function automatic int half_of(input int p);
        return PITCH_BASE - PITCH_STEP * p;
    endfunction

    function automatic int tick_of(input int t);
        return TEMPO_BASE + TEMPO_STEP * t;
    endfunction

    function automatic logic [7:0] word(input int len, input int pitch);
        return {3'(len), 5'(pitch)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [7:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 6'(a);
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop_play();
        @(negedge clk);
        play_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // raise the enable, return the edge count at which the tone first reads high
    task automatic start_and_rise(output int n);
        @(negedge clk);
        play_en = 1'b1;
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (tone_out) break;
        end
    endtask

    // count consecutive samples equal to the current one (current included)
    task automatic run_len(input logic val, input int cap, output int c);
        c = 1;
        for (int i = 0; i < cap; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (tone_out === val) c++;
            else break;
        end
    endtask

    task automatic quiet_for(input int cyc, output int highs);
        highs = 0;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (tone_out !== 1'b0) highs++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 tone low in reset", int'(tone_out), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 tone low after reset", int'(tone_out), 0);
    endtask

    task automatic t_start_and_pitch();
        int n, h, l;
        tempo_code = 5'd3;
        put(0, word(7, 0));       // R11: words written through the port
        put(1, 8'h5F);
        start_and_rise(n);
        chk("R2 start delay edges", n, DELAY + 2);
        run_len(1'b1, 200, h);
        chk("R6 high phase code 0", h, half_of(0));
        run_len(1'b0, 200, l);
        chk("R6 low phase code 0", l, half_of(0));
        // tone is high here: drop the enable mid-phase
        @(negedge clk);
        play_en = 1'b0;
        #1;
        chk("R1 tone low at once", int'(tone_out), 0);
        quiet_for(50, h);
        chk("R1 stays low while off", h, 0);
    endtask

    task automatic t_high_pitch_rearm();
        int n, h;
        put(0, word(7, 26));
        start_and_rise(n);
        chk("R9 rearmed delay", n, DELAY + 2);
        run_len(1'b1, 200, h);
        chk("R6 high phase code 26", h, half_of(26));
        stop_play();
    endtask

    task automatic t_rest_and_wrap();
        int n, h, l, h2;
        tempo_code = 5'd0;
        put(0, word(0, 5));
        put(1, word(4, 31));
        put(2, 8'h5F);
        put(3, word(0, 0));
        put(4, word(7, 9));
        start_and_rise(n);
        run_len(1'b1, 200, h);
        chk("R3 one-tick note length", h, ticks_of(0) * tick_of(0) + 1);
        run_len(1'b0, 200, l);
        chk("R7 rest plus end word low", l, ticks_of(4) * tick_of(0) + 1 + 1);
        run_len(1'b1, 200, h2);
        chk("R5 wrap replays only head", h2, ticks_of(0) * tick_of(0) + 1);
        stop_play();
    endtask

    task automatic t_tempo();
        int n, h, l;
        tempo_code = 5'd4;
        put(0, word(2, 3));
        put(1, word(1, 31));
        put(2, 8'h5F);
        start_and_rise(n);
        run_len(1'b1, 200, h);
        chk("R4 tempo 4 three ticks", h, ticks_of(2) * tick_of(4) + 1);
        run_len(1'b0, 200, l);
        chk("R4 tempo 4 rest of two ticks", l, ticks_of(1) * tick_of(4) + 2);
        stop_play();
    endtask

    task automatic t_silent_code();
        int n;
        tempo_code = 5'd0;
        put(0, word(3, 28));
        put(1, 8'h5F);
        @(negedge clk);
        play_en = 1'b1;
        quiet_for(200, n);
        chk("R7 code 28 silent", n, 0);
        stop_play();
    endtask

    task automatic t_end_first();
        int n;
        put(0, 8'h5F);
        put(1, word(7, 0));
        @(negedge clk);
        play_en = 1'b1;
        quiet_for(200, n);
        chk("R5 end word at address 0 silent", n, 0);
        stop_play();
    endtask

    task automatic t_tie();
        int n, h, l;
        tempo_code = 5'd0;
        put(0, word(0, 0));
        put(1, word(0, 0));
        put(2, 8'h5F);
        start_and_rise(n);
        run_len(1'b1, 300, h);
        chk("R8 tied high phase", h, half_of(0));
        run_len(1'b0, 300, l);
        chk("R8 tied low phase", l, half_of(0));
        stop_play();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_start_and_pitch();
        t_high_pitch_rearm();
        t_rest_and_wrap();
        t_tempo();
        t_silent_code();
        t_end_first();
        t_tie();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule